// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

The block buffers 36-bit words in one direction, from a write side clocked by `a_clk` to a read side clocked by `b_clk`. The two clocks may be unrelated, or the same net. Each side has an active-low select, a direction input and an enable, and a transfer happens on a rising edge of that side's clock only when all three allow it. The write side reports an active-low full flag and an almost-full flag. The read side reports an active-low empty flag and an almost-empty flag.

Each pointer crosses into the other domain as a Gray code through a two-stage synchronizer. Each flag is computed in its own domain from that domain's live pointer and the synchronized, possibly stale, pointer of the other side. A flag can therefore release late, but it never asserts late. The almost thresholds share one offset. That offset is taken from a two-bit select input while reset is held low, and is kept until the next reset.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: While `rst_n` is low, and after it rises with no traffic: `b_empty_n`=0, `b_aempty`=1, `a_full_n`=1, `a_afull`=0 and `b_data`=0.
- R2: A write is accepted on a rising `a_clk` edge only when `a_cs_n`=0, `a_wr`=1, `a_en`=1 and `a_full_n`=1. A read is accepted on a rising `b_clk` edge only when `b_cs_n`=0, `b_rd`=1, `b_en`=1 and `b_empty_n`=1. An accepted read places the oldest stored word on `b_data` after that edge, so words leave in the order they were written.
- R3: The FIFO holds at most 64 words. `a_full_n` is 0 exactly when the written count minus the synchronized read count equals 64.
- R4: A write attempted while `a_full_n`=0 stores nothing and does not advance the write pointer.
- R5: A read attempted while `b_empty_n`=0 is ignored, and `b_data` keeps its previous value.
- R6: Each pointer reaches the other domain through two flops. With a shared clock, a word written on edge n makes `b_empty_n` rise after edge n+2, and a read on edge n frees space as seen by `a_full_n` after edge n+2.
- R7: `a_afull`=1 when the write-side count is at least 64 minus the offset. `b_aempty`=1 when the read-side count is at most the offset.
- R8: The offset is sampled from `thr_sel` while `rst_n` is low: 00 gives 16, 01 gives 12, 10 gives 8, 11 gives 4. Changing `thr_sel` after reset has no effect.
- R9: `a_full_n` falls after the same edge that stores the 64th word. `b_empty_n` falls after the same edge that reads the last word.
- R10: With a shared clock, a read and a write on the same edge both complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| thr_sel | input | 2 | Offset select, sampled during reset |
| a_clk | input | 1 | Write-side clock |
| a_cs_n | input | 1 | Write-side select, active low |
| a_wr | input | 1 | Write-side direction, 1 = write |
| a_en | input | 1 | Write-side enable |
| a_data | input | 36 | Write data |
| a_full_n | output | 1 | Full flag, active low |
| a_afull | output | 1 | Almost-full flag |
| b_clk | input | 1 | Read-side clock |
| b_cs_n | input | 1 | Read-side select, active low |
| b_rd | input | 1 | Read-side direction, 1 = read |
| b_en | input | 1 | Read-side enable |
| b_data | output | 36 | Read data, registered |
| b_empty_n | output | 1 | Empty flag, active low |
| b_aempty | output | 1 | Almost-empty flag |

## Verification
The bench fills the FIFO past capacity and drains it past empty. A design that let a write through while full would corrupt the word stream, and one that advanced the read pointer while empty would show a wrong or changed `b_data`. It checks the two-edge delay on flag release with a single word. A missing synchronizer stage would release a flag early, and an extra stage would release it late. It changes `thr_sel` after reset and repeats reset with every offset, which catches thresholds that are off by one or that follow the live select input. It also streams simultaneous reads and writes on a shared clock, where a design that gives one side priority would lose words.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    localparam int unsigned FIFO_DW = 36;
    localparam int unsigned FIFO_AW = 6;
    localparam int unsigned DEPTH   = 1 << FIFO_AW;
    localparam int unsigned PW      = FIFO_AW + 1;
    localparam int unsigned SYNC_STAGES = 2;

    typedef logic [PW-1:0] ptr_t;

    typedef struct packed {
        ptr_t bin;
        ptr_t gray;
    } ptr_state_t;

    function automatic ptr_t bin2gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(ptr_t g);
        ptr_t b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // 00 -> DEPTH/4, each step lowers the offset by DEPTH/16
    function automatic ptr_t sel_offset(logic [1:0] sel);
        int unsigned v;
        v = DEPTH / 4 - int'(sel) * (DEPTH / 16);
        return ptr_t'(v);
    endfunction

endpackage

// File: rtl/gray_sync.sv
module gray_sync
    import fifo_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  ptr_t din,
    output ptr_t dout
);

    ptr_t stage_q [STAGES];
    ptr_t stage_d [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = din;
            end else begin : g_next
                always_comb stage_d[g] = stage_q[g-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/fifo_ram.sv
module fifo_ram
    import fifo_pkg::*;
#(
    parameter int unsigned DW = FIFO_DW,
    parameter int unsigned AW = FIFO_AW
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] rdata_d, rdata_q;

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = mem[raddr];
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    AST_RDATA_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
        !re |=> $stable(rdata)) else $error("read data moved without a read"); // R5

endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
    import fifo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         thr_sel,
    input  logic               cs_n,
    input  logic               wr,
    input  logic               en,
    input  ptr_t               rgray_sync,
    output logic               push,
    output logic [FIFO_AW-1:0] waddr,
    output ptr_t               wgray,
    output logic               full_n,
    output logic               afull
);

    localparam ptr_t DEPTH_P = ptr_t'(DEPTH);

    ptr_state_t st_d, st_q;
    ptr_t       off_q;
    ptr_t       rbin;
    ptr_t       used;
    logic       full;

    // offset follows the select input only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= sel_offset(thr_sel);
    end

    always_comb begin
        rbin  = gray2bin(rgray_sync);
        used  = st_q.bin - rbin;
        full  = (used == DEPTH_P);
        push  = !cs_n && wr && en && !full;
        st_d.bin  = st_q.bin + (push ? ptr_t'(1) : ptr_t'(0));
        st_d.gray = bin2gray(st_d.bin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr  = st_q.bin[FIFO_AW-1:0];
    assign wgray  = st_q.gray;
    assign full_n = !full;
    assign afull  = (used >= (DEPTH_P - off_q));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        used <= DEPTH_P) else $error("write side count above depth"); // R3
    AST_WPTR_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !cs_n && wr && en) |=> $stable(st_q.bin)) else $error("write while full moved pointer"); // R4
    AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1) else $error("write gray pointer changed several bits"); // R6
    AST_AFULL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> afull) else $error("full without almost-full"); // R7
    AST_WOFF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(off_q)) else $error("write offset changed outside reset"); // R8

endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         thr_sel,
    input  logic               cs_n,
    input  logic               rd,
    input  logic               en,
    input  ptr_t               wgray_sync,
    output logic               pop,
    output logic [FIFO_AW-1:0] raddr,
    output ptr_t               rgray,
    output logic               empty_n,
    output logic               aempty
);

    localparam ptr_t DEPTH_P = ptr_t'(DEPTH);

    ptr_state_t st_d, st_q;
    ptr_t       off_q;
    ptr_t       wbin;
    ptr_t       used;
    logic       empty;

    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= sel_offset(thr_sel);
    end

    always_comb begin
        wbin  = gray2bin(wgray_sync);
        used  = wbin - st_q.bin;
        empty = (used == '0);
        pop   = !cs_n && rd && en && !empty;
        st_d.bin  = st_q.bin + (pop ? ptr_t'(1) : ptr_t'(0));
        st_d.gray = bin2gray(st_d.bin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr   = st_q.bin[FIFO_AW-1:0];
    assign rgray   = st_q.gray;
    assign empty_n = !empty;
    assign aempty  = (used <= off_q);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        used <= DEPTH_P) else $error("read side count wrapped"); // R3
    AST_RPTR_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !cs_n && rd && en) |=> $stable(st_q.bin)) else $error("read while empty moved pointer"); // R5
    AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1) else $error("read gray pointer changed several bits"); // R6
    AST_AEMPTY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> aempty) else $error("empty without almost-empty"); // R7
    AST_ROFF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(off_q)) else $error("read offset changed outside reset"); // R8

endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
    import fifo_pkg::*;
#(
    parameter int unsigned DATA_W = FIFO_DW
) (
    input  logic              rst_n,
    input  logic [1:0]        thr_sel,
    input  logic              a_clk,
    input  logic              a_cs_n,
    input  logic              a_wr,
    input  logic              a_en,
    input  logic [DATA_W-1:0] a_data,
    output logic              a_full_n,
    output logic              a_afull,
    input  logic              b_clk,
    input  logic              b_cs_n,
    input  logic              b_rd,
    input  logic              b_en,
    output logic [DATA_W-1:0] b_data,
    output logic              b_empty_n,
    output logic              b_aempty
);

    logic               push, pop;
    logic [FIFO_AW-1:0] waddr, raddr;
    ptr_t               wgray, rgray;
    ptr_t               wgray_s, rgray_s;

    fifo_wr_ctl u_wr (
        .clk        (a_clk),
        .rst_n      (rst_n),
        .thr_sel    (thr_sel),
        .cs_n       (a_cs_n),
        .wr         (a_wr),
        .en         (a_en),
        .rgray_sync (rgray_s),
        .push       (push),
        .waddr      (waddr),
        .wgray      (wgray),
        .full_n     (a_full_n),
        .afull      (a_afull)
    );

    fifo_rd_ctl u_rd (
        .clk        (b_clk),
        .rst_n      (rst_n),
        .thr_sel    (thr_sel),
        .cs_n       (b_cs_n),
        .rd         (b_rd),
        .en         (b_en),
        .wgray_sync (wgray_s),
        .pop        (pop),
        .raddr      (raddr),
        .rgray      (rgray),
        .empty_n    (b_empty_n),
        .aempty     (b_aempty)
    );

    gray_sync u_w2r (
        .clk   (b_clk),
        .rst_n (rst_n),
        .din   (wgray),
        .dout  (wgray_s)
    );

    gray_sync u_r2w (
        .clk   (a_clk),
        .rst_n (rst_n),
        .din   (rgray),
        .dout  (rgray_s)
    );

    fifo_ram #(.DW(DATA_W), .AW(FIFO_AW)) u_ram (
        .wclk  (a_clk),
        .we    (push),
        .waddr (waddr),
        .wdata (a_data),
        .rclk  (b_clk),
        .rst_n (rst_n),
        .re    (pop),
        .raddr (raddr),
        .rdata (b_data)
    );

    AST_RDATA_HOLD_EMPTY: assert property (@(posedge b_clk) disable iff (!rst_n)
        (!b_empty_n && !b_cs_n && b_rd && b_en) |=> $stable(b_data)) else $error("read while empty changed data"); // R5
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge a_clk) disable iff (!rst_n)
        !a_full_n |-> !push) else $error("store issued while full"); // R4

endmodule

// File: tb/dual_clock_flag_fifo_test.sv
`timescale 1ns/1ps
module dual_clock_flag_fifo_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  thr_sel = 2'b00;
    logic        a_cs_n = 1'b1, a_wr = 1'b0, a_en = 1'b0;
    logic [35:0] a_data = '0;
    logic        b_cs_n = 1'b1, b_rd = 1'b0, b_en = 1'b0;
    logic        a_full_n, a_afull, b_empty_n, b_aempty;
    logic [35:0] b_data;

    always #5 clk = ~clk;

    dual_clock_flag_fifo uut (
        .rst_n(rst_n), .thr_sel(thr_sel),
        .a_clk(clk), .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_data(a_data),
        .a_full_n(a_full_n), .a_afull(a_afull),
        .b_clk(clk), .b_cs_n(b_cs_n), .b_rd(b_rd), .b_en(b_en), .b_data(b_data),
        .b_empty_n(b_empty_n), .b_aempty(b_aempty)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string ctx = "";

    // reference model state
    logic [35:0] q[$];
    int w_now, w_d1, w_d2, r_now, r_d1, r_d2;
    int off_exp;
    logic [35:0] data_exp;
    int seq = 0;

    task automatic chk(input string what, input logic [35:0] got, input logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%0h exp=%0h", ctx, what, got, exp);
        end
    endtask

    function automatic int cnt_a(); return w_now - r_d2; endfunction
    function automatic int cnt_b(); return w_d2 - r_now; endfunction

    task automatic compare_all();
        chk("a_full_n R3 R9", a_full_n, (cnt_a() == 64) ? 1'b0 : 1'b1);
        chk("a_afull R7",    a_afull,  (cnt_a() >= 64 - off_exp) ? 1'b1 : 1'b0);
        chk("b_empty_n R9",  b_empty_n, (cnt_b() == 0) ? 1'b0 : 1'b1);
        chk("b_aempty R7",   b_aempty, (cnt_b() <= off_exp) ? 1'b1 : 1'b0);
        chk("b_data R2",     b_data, data_exp);
    endtask

    task automatic step(input bit aw, input bit ac, input bit ae,
                        input bit br, input bit bc, input bit be);
        bit wacc, racc;
        seq++;
        a_cs_n = !ac; a_wr = aw; a_en = ae;
        a_data = {4'(seq) ^ 4'h9, 32'(seq * 32'h9E37_79B1)};
        b_cs_n = !bc; b_rd = br; b_en = be;
        wacc = ac && aw && ae && (cnt_a() != 64);
        racc = bc && br && be && (cnt_b() != 0);
        @(posedge clk);
        if (wacc) q.push_back(a_data);
        if (racc) data_exp = q.pop_front();
        w_d2 = w_d1; w_d1 = w_now; w_now += int'(wacc);
        r_d2 = r_d1; r_d1 = r_now; r_now += int'(racc);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr1(); step(1, 1, 1, 0, 0, 0); endtask
    task automatic rd1(); step(0, 0, 0, 1, 1, 1); endtask
    task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk);
        rst_n = 1'b0;
        thr_sel = sel;
        a_cs_n = 1'b1; b_cs_n = 1'b1; a_en = 0; b_en = 0; a_wr = 0; b_rd = 0;
        q.delete();
        w_now = 0; w_d1 = 0; w_d2 = 0; r_now = 0; r_d1 = 0; r_d2 = 0;
        data_exp = '0;
        off_exp = 16 - 4 * int'(sel);
        repeat (3) @(negedge clk);
        ctx = "R1 in reset";
        chk("b_empty_n", b_empty_n, 1'b0);
        chk("b_aempty", b_aempty, 1'b1);
        chk("a_full_n", a_full_n, 1'b1);
        chk("a_afull", a_afull, 1'b0);
        chk("b_data", b_data, 36'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired, run hung");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // offset 16
        do_reset(2'b00);
        ctx = "R1 after reset";
        idle();

        // R6: one word needs two edges to clear empty
        ctx = "R6 latency";
        wr1();
        chk("R6 empty after 1 edge", b_empty_n, 1'b0);
        idle();
        chk("R6 empty still set", b_empty_n, 1'b0);
        idle();
        chk("R6 empty released", b_empty_n, 1'b1);
        rd1();
        chk("R9 empty on last read", b_empty_n, 1'b0);

        // R2: gating by select, enable and direction
        ctx = "R2 gating";
        step(1, 0, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0);
        repeat (3) idle();
        chk("R2 nothing stored", b_empty_n, 1'b0);
        for (int i = 0; i < 6; i++) wr1();
        repeat (2) idle();
        step(0, 0, 1, 1, 1, 1);
        step(0, 1, 1, 1, 0, 1);
        step(0, 1, 1, 0, 1, 1);
        for (int i = 0; i < 3; i++) rd1();

        // R3/R4/R9: overfill
        ctx = "R4 overfill";
        for (int i = 0; i < 72; i++) wr1();
        chk("R4 full held", a_full_n, 1'b0);
        repeat (3) idle();

        // R8: select changed after reset, thresholds stay at 16
        ctx = "R8 late select";
        thr_sel = 2'b11;
        // R5: drain past empty
        for (int i = 0; i < 75; i++) rd1();
        ctx = "R5 read empty";
        for (int i = 0; i < 4; i++) rd1();
        chk("R5 data held", b_data, data_exp);

        // R10: simultaneous read and write on one edge
        ctx = "R10 stream";
        for (int i = 0; i < 20; i++) wr1();
        repeat (2) idle();
        for (int i = 0; i < 100; i++) step(1, 1, 1, 1, 1, 1);
        for (int i = 0; i < 60; i++) step(1, 1, 1, i % 3 == 0, 1, 1);
        for (int i = 0; i < 90; i++) step(i % 4 == 0, 1, 1, 1, 1, 1);

        // R8: other offsets
        for (int s = 1; s < 4; s++) begin
            do_reset(2'(s));
            ctx = $sformatf("R8 offset sel %0d", s);
            for (int i = 0; i < 66; i++) wr1();
            repeat (3) idle();
            for (int i = 0; i < 66; i++) rd1();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule